// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block is the receive-side write engine of a simple Ethernet controller. Frames that have already passed filtering and CRC checking arrive one byte per cycle. The block stores each frame in a circular buffer in host memory through a byte-wide write port. Every stored frame sits behind a 4-byte little-endian header. The header holds the frame length and a status word built from the error and address-class flags that came with the frame. The next frame begins at the first 4-byte-aligned offset past the current one.

The host consumes frames and hands space back by writing a read pointer. That pointer is kept sixteen bytes behind the true read offset. The block compares its own write offset with that read offset to drive a buffer-empty flag. It refuses any frame that would run over unread data: the frame is dropped and an overflow event is raised. A small set of sticky event bits, cleared by writing ones, reports stored frames, errored frames, ring overflow and bytes that arrived outside a frame.

Top module: `rx_ring_writer`

## Requirements
- R1: The ring holds `2**BASE_LOG2 << k` bytes, where k is `size_sel`, and a `size_sel` value of 3 acts as 2. Every write address is below the ring size.
- R2: Data byte i of a frame whose header sits at offset `off` is written to `(off + 4 + i) mod size`. Frame data therefore wraps from the end of the ring to offset 0.
- R3: The header occupies `off` to `off+3`, least significant byte first. Bytes 0–1 hold the status word and bytes 2–3 hold `frm_len`. All four header bytes are written after the last data byte of the frame.
- R4: Status bit 0 is 1 exactly when all of `frm_err` is zero. Status bits 5:1 copy `frm_err[4:0]` (bad alignment, CRC, too long, runt, bad symbol). Bits 15:13 copy `frm_cls[2:0]` (multicast, physical match, broadcast). All other status bits are 0.
- R5: After a stored frame, the write offset becomes `(off + frm_len + 7)` with the low two bits cleared, taken mod size. A zero-length frame stores only its header.
- R6: The read offset is `(hptr + 16) mod size`, where `hptr` is the last value written through `hptr_we`. After reset `hptr` equals −16, so the read offset starts at 0.
- R7: `buf_empty` is 1 exactly when the read offset equals the write offset. It is 1 after reset.
- R8: A frame is accepted only if `(frm_len + 7) & ~3` is less than the free space. The free space is the ring size when the ring is empty, and `(read − write) mod size` otherwise. A refused frame produces no writes, leaves the write offset unchanged, and sets event bit 4.
- R9: When the header of a stored frame completes, event bit 0 is set if status bit 0 is 1. Otherwise event bit 1 is set.
- R10: Event bit 6 is set in either of two cases: a byte is presented while no frame is being received, or `frm_start` arrives while a frame is still in progress. The second start is ignored.
- R11: Event bits are sticky and are cleared by a 1 on the matching `evt_clr` bit. A new event in the same cycle as its clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_sel | input | 2 | Ring size index, held static between resets |
| frm_start | input | 1 | Start of a frame; samples length and flags |
| frm_len | input | 16 | Frame byte count including FCS |
| frm_err | input | 5 | Error flags of the frame |
| frm_cls | input | 3 | Address class flags of the frame |
| byte_valid | input | 1 | Frame byte present |
| byte_data | input | 8 | Frame byte |
| hptr_we | input | 1 | Host read pointer write strobe |
| hptr_wdata | input | BASE_LOG2+2 | Host read pointer (consumed offset − 16) |
| evt_clr | input | 8 | Write-one-to-clear for event bits |
| evt | output | 8 | Sticky event bits |
| buf_empty | output | 1 | No unread frame in the ring |
| mem_we | output | 1 | Ring write strobe |
| mem_addr | output | BASE_LOG2+2 | Ring byte offset |
| mem_wdata | output | 8 | Ring write byte |

## Verification
A byte presented at one clock edge appears on the write port during the following cycle. The four header bytes follow the last data byte on four consecutive cycles. The bench therefore waits eight cycles after a frame's last byte before it inspects its model memory, the event bits and `buf_empty`.

The write offset moves on the same edge as the last header byte. A pointer write takes effect at the next edge. For that reason the empty flag is sampled one cycle after each pointer write, and event bits are sampled one cycle after the event or the clear.

Every check is taken on the falling edge, halfway between the edges that drive the stimulus and the results.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int BASE_LOG2 = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             size_sel,
  input  logic                   frm_start,
  input  logic [15:0]            frm_len,
  input  logic [4:0]             frm_err,
  input  logic [2:0]             frm_cls,
  input  logic                   byte_valid,
  input  logic [7:0]             byte_data,
  input  logic                   hptr_we,
  input  logic [BASE_LOG2+1:0]   hptr_wdata,
  input  logic [7:0]             evt_clr,
  output logic [7:0]             evt,
  output logic                   buf_empty,
  output logic                   mem_we,
  output logic [BASE_LOG2+1:0]   mem_addr,
  output logic [7:0]             mem_wdata
);
  localparam int OFF_W = BASE_LOG2 + 2;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_DROP, S_HDR} st_t;
  st_t st;

  logic [OFF_W-1:0] wr_off, hptr, rd_off, mask, diff, nxt, data_addr;
  logic [1:0]  sz_c, hcnt;
  logic [16:0] ring_size, free_sp, need;
  logic [15:0] cur_len, cur_stat, cnt, stat_new;
  logic [31:0] hdr_w;
  logic [7:0]  evt_set;
  logic        fits;

  assign sz_c      = (size_sel == 2'd3) ? 2'd2 : size_sel;
  assign mask      = {OFF_W{1'b1}} >> (2'd2 - sz_c);
  assign ring_size = 17'(mask) + 17'd1;
  assign rd_off    = (hptr + OFF_W'(16)) & mask;
  assign buf_empty = (rd_off == wr_off);
  assign diff      = (rd_off - wr_off) & mask;
  assign free_sp   = buf_empty ? ring_size : 17'(diff);
  assign need      = (17'(frm_len) + 17'd7) & ~17'd3;
  assign fits      = need < free_sp;
  assign nxt       = (wr_off + OFF_W'(cur_len) + OFF_W'(7)) & mask & ~OFF_W'(3);
  assign data_addr = (wr_off + OFF_W'(cnt) + OFF_W'(4)) & mask;
  assign stat_new  = {frm_cls, 7'd0, frm_err, ~|frm_err};
  assign hdr_w     = {cur_len, cur_stat};

  always_comb begin
    evt_set = '0;
    if (frm_start && st != S_IDLE) evt_set[6] = 1'b1;
    if (byte_valid && (st == S_IDLE || st == S_HDR)) evt_set[6] = 1'b1;
    if (st == S_IDLE && frm_start && !fits) evt_set[4] = 1'b1;
    if (st == S_HDR && hcnt == 2'd3) begin
      if (cur_stat[0]) evt_set[0] = 1'b1;
      else             evt_set[1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wr_off    <= '0;
      hptr      <= {OFF_W{1'b1}} << 4;
      evt       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cnt       <= '0;
      hcnt      <= '0;
      cur_len   <= '0;
      cur_stat  <= '0;
    end else begin
      mem_we <= 1'b0;
      if (hptr_we) hptr <= hptr_wdata;
      evt <= (evt & ~evt_clr) | evt_set;
      case (st)
        S_IDLE: if (frm_start) begin
          cur_len  <= frm_len;
          cur_stat <= stat_new;
          cnt      <= '0;
          hcnt     <= '0;
          if (!fits) st <= (frm_len == 16'd0) ? S_IDLE : S_DROP;
          else       st <= (frm_len == 16'd0) ? S_HDR  : S_DATA;
        end
        S_DATA: if (byte_valid) begin
          mem_we    <= 1'b1;
          mem_addr  <= data_addr;
          mem_wdata <= byte_data;
          cnt       <= cnt + 16'd1;
          if (cnt == cur_len - 16'd1) st <= S_HDR;
        end
        S_DROP: if (byte_valid) begin
          cnt <= cnt + 16'd1;
          if (cnt == cur_len - 16'd1) st <= S_IDLE;
        end
        S_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= {wr_off[OFF_W-1:2], hcnt};
          mem_wdata <= hdr_w[{hcnt, 3'b000} +: 8];
          hcnt      <= hcnt + 2'd1;
          if (hcnt == 2'd3) begin
            wr_off <= nxt;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (17'(mem_addr) < ring_size));

  // R3
  hdr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_off != $past(wr_off)) |-> $past(st == S_HDR && hcnt == 2'd3));

  // R5
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off[1:0] == 2'b00);

  // R8
  drop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == S_DROP) |-> !mem_we);

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt[4]) |-> $past(frm_start));

  // R7
  empty_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_empty) |-> ($past(st == S_HDR) || $past(hptr_we)));
endmodule

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;
  localparam int BL = 8;
  localparam int OW = BL + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] size_sel = '0;
  logic frm_start = 0, byte_valid = 0, hptr_we = 0;
  logic [15:0] frm_len = '0;
  logic [4:0] frm_err = '0;
  logic [2:0] frm_cls = '0;
  logic [7:0] byte_data = '0, evt_clr = '0;
  logic [OW-1:0] hptr_wdata = '0;
  logic [7:0] evt;
  logic buf_empty, mem_we;
  logic [OW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  rx_ring_writer #(.BASE_LOG2(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .frm_start(frm_start),
    .frm_len(frm_len), .frm_err(frm_err), .frm_cls(frm_cls),
    .byte_valid(byte_valid), .byte_data(byte_data), .hptr_we(hptr_we),
    .hptr_wdata(hptr_wdata), .evt_clr(evt_clr), .evt(evt),
    .buf_empty(buf_empty), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata));

  always #2 clk = ~clk;

  logic [7:0] mem [0:(1<<OW)-1];
  int checks = 0, errors = 0, cyc = 0, first_hdr = -1, last_data = -1, wcnt = 0;
  int ring = 256, exp_wr = 0, cur_off = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wcnt <= wcnt + 1;
      if (((int'(mem_addr) - cur_off) & (ring - 1)) < 4) begin
        if (first_hdr < 0) first_hdr <= cyc;
      end else last_data <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int len);
    return 8'((i * 7 + len * 13) & 255);
  endfunction

  function automatic logic [15:0] stfix(input logic [4:0] e, input logic [2:0] c);
    return {c, 7'd0, e, ~|e};
  endfunction

  task automatic do_reset(input int idx);
    rst_n = 0; size_sel = 2'(idx);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ring = 256 << ((idx > 2) ? 2 : idx);
    exp_wr = 0;
  endtask

  task automatic send(input int len, input logic [4:0] e, input logic [2:0] c, input int dup);
    @(negedge clk);
    frm_start = 1; frm_len = 16'(len); frm_err = e; frm_cls = c;
    @(negedge clk);
    frm_start = 0;
    for (int i = 0; i < len; i++) begin
      byte_valid = 1; byte_data = pat(i, len);
      frm_start = (i == dup);
      @(negedge clk);
    end
    byte_valid = 0; frm_start = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic consume(input int off);
    hptr_wdata = OW'(off - 16); hptr_we = 1;
    @(negedge clk);
    hptr_we = 0;
  endtask

  task automatic clear_evt(input logic [7:0] m);
    evt_clr = m;
    @(negedge clk);
    evt_clr = '0;
  endtask

  task automatic frame_ok(input int len, input logic [4:0] e, input logic [2:0] c,
                          input bit cons, input int dup);
    int off, bad;
    logic [31:0] hdr, exph;
    off = exp_wr; cur_off = off;
    first_hdr = -1; last_data = -1;
    send(len, e, c, dup);
    hdr = {mem[(off+3)%ring], mem[(off+2)%ring], mem[(off+1)%ring], mem[off]};
    exph = {16'(len), stfix(e, c)};
    chk(hdr == exph, "R3 R4 header", hdr, exph);
    bad = 0;
    for (int i = 0; i < len; i++)
      if (mem[(off + 4 + i) % ring] !== pat(i, len)) bad++;
    chk(bad == 0, "R2 data in ring R1", bad, 0);
    if (len > 0) chk(first_hdr > last_data, "R3 header after data", first_hdr, last_data);
    chk(buf_empty == 0, "R7 not empty after frame", buf_empty, 0);
    if (e == 0) chk(evt[1:0] == 2'b01, "R9 ok event", evt, 1);
    else        chk(evt[1:0] == 2'b10, "R9 error event", evt, 2);
    clear_evt(8'hFF);
    chk(evt == 0, "R11 clear", evt, 0);
    exp_wr = ((off + len + 7) & ~3) % ring;
    if (cons) begin
      consume(exp_wr);
      chk(buf_empty == 1, "R5 R6 R7 empty after consume", buf_empty, 1);
    end
  endtask

  initial begin
    for (int idx = 0; idx < 4; idx++) begin
      do_reset(idx);
      chk(buf_empty == 1, "R6 R7 reset empty", buf_empty, 1);
      chk(evt == 0, "R11 reset events", evt, 0);
      chk(mem_we == 0, "R3 reset no write", mem_we, 0);
      for (int len = 0; len <= 150; len++) begin
        logic [4:0] e;
        e = ((len % 5) == 0) ? 5'(len) : 5'd0;
        frame_ok(len, e, 3'(len), 1, -1);
      end
    end

    do_reset(0);
    for (int k = 0; k < 3; k++) frame_ok(60, 5'd0, 3'd1, 0, -1);
    chk(exp_wr == 192, "R5 offset after fills", exp_wr, 192);
    wcnt = 0;
    send(60, 5'd0, 3'd1, -1);
    chk(wcnt == 0, "R8 no writes when full", wcnt, 0);
    chk(evt[4] == 1, "R8 overflow event", evt, 16);
    chk(evt[1:0] == 0, "R8 no store event", evt, 0);
    clear_evt(8'h10);
    chk(evt[4] == 0, "R11 overflow clear", evt, 0);
    consume(192);
    chk(buf_empty == 1, "R8 offset unchanged", buf_empty, 1);
    frame_ok(10, 5'd0, 3'd4, 1, -1);

    byte_valid = 1; byte_data = 8'hAA;
    @(negedge clk);
    byte_valid = 0;
    @(negedge clk);
    chk(evt[6] == 1, "R10 stray byte", evt, 64);
    chk(buf_empty == 1, "R10 stray byte not stored", buf_empty, 1);
    evt_clr = 8'h40; byte_valid = 1;
    @(negedge clk);
    evt_clr = 0; byte_valid = 0;
    @(negedge clk);
    chk(evt[6] == 1, "R11 set wins over clear", evt, 64);
    clear_evt(8'hFF);

    frame_ok(20, 5'd0, 3'd2, 0, 3);
    chk(evt == 0, "R10 cleared by frame_ok", evt, 0);
    consume(exp_wr);
    chk(buf_empty == 1, "R10 second start ignored", buf_empty, 1);
    evt_clr = 0;
    send(20, 5'd0, 3'd2, 3);
    chk(evt[6] == 1 && evt[0] == 1, "R10 start while busy", evt, 65);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule